// File: doc/BRIEF.md
# Two-Level Gated Event Interrupt Unit

This block gathers four single-cycle event pulses from a touch-sensing sequencer and records them as sticky status flags that software clears. Each event passes two gates. A per-event capture enable decides whether the pulse may set its flag at all. A second, per-event interrupt enable then decides whether that flag may drive the shared interrupt line. The four events are: measurement complete, touch detected, touch still present after measurement (called "valid"), and return to idle after a software stop request. The valid event can never raise the interrupt on its own, because it has no interrupt enable. Clearing the measurement flag also drops the valid flag, since the two describe the same measurement.

Software reaches the block through a small register port. Writes take effect on the clock edge, and reads are combinational from the address. The event sources sit outside this block and feed it only through the pulse inputs. The interrupt output is a level. It stays high as long as any flag is set while both of its enables are set.

Top module: `evt_irq_gate`

## Requirements
- R1: After reset, the status, capture-enable and interrupt-enable registers read zero and `irq` is low.
- R2: Bit positions are fixed: bit 0 = measure done, bit 1 = detect, bit 2 = valid, bit 3 = idle-after-stop. A flag is set on a clock edge only when its `evt_pulse` bit is 1 and its capture-enable bit is 1 at that edge. No other event sets it.
- R3: In the interrupt-enable register, bits 0, 1 and 3 can be written and read back. Bit 2 (valid) always reads 0, and writing it has no effect on `irq`.
- R4: A write to the status address clears each flag whose data bit is 1. Flags whose data bit is 0 are kept.
- R5: A status write with bit 0 set also clears flag bit 2, even when data bit 2 is 0.
- R6: If a flag is set and cleared on the same edge, it ends set.
- R7: `irq` is high exactly when some flag, its capture enable and its interrupt enable are all 1. The valid flag never counts toward `irq`.
- R8: Clearing a capture-enable bit leaves an already set flag in place, but it removes that flag from `irq` until the enable returns.
- R9: Address 0 is status, address 1 is capture enable, address 2 is interrupt enable. Any other address reads zero, and writes to it change nothing. `reg_rdata` follows `reg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data for `reg_addr` |
| evt_pulse | input | 4 | Event pulses, one bit per event |
| irq | output | 1 | Level interrupt |

## Verification
The main sweep tries every combination of capture-enable mask, interrupt-enable mask and event pattern. This shows whether each gate acts on the right bit and whether the valid bit leaks into the interrupt. Directed sequences then cover several things: a set and a clear in the same cycle, a measure clear that must take the valid flag with it, partial and all-zero clear writes, removing a capture enable while a flag is pending, and writes to an unmapped address. These separate the clearing rules from the setting rules.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int NUM_EVT  = 4;
    localparam int EV_MEAS  = 0;
    localparam int EV_DET   = 1;
    localparam int EV_VALID = 2;
    localparam int EV_IDLE  = 3;

    localparam int ADDR_STAT  = 0;
    localparam int ADDR_SIGEN = 1;
    localparam int ADDR_IRQEN = 2;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    // events that own an interrupt enable bit
    localparam evt_vec_t IRQ_CAPABLE = evt_vec_t'((1 << EV_MEAS) | (1 << EV_DET) | (1 << EV_IDLE));

    typedef struct packed {
        evt_vec_t sig_en;
        evt_vec_t irq_en;
    } en_state_t;

    typedef struct packed {
        evt_vec_t flags;
    } flag_state_t;
endpackage

// File: rtl/evt_irq_enables.sv
module evt_irq_enables
    import evt_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_sig,
    input  logic     wr_irq,
    input  evt_vec_t wdata,
    output evt_vec_t sig_en,
    output evt_vec_t irq_en
);
    en_state_t en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr_sig) begin
            en_d.sig_en = wdata;
        end
        if (wr_irq) begin
            en_d.irq_en = wdata & IRQ_CAPABLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign sig_en = en_q.sig_en;
    assign irq_en = en_q.irq_en;
endmodule

// File: rtl/evt_irq_flags.sv
module evt_irq_flags
    import evt_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t evt,
    input  evt_vec_t sig_en,
    input  logic     clr_stb,
    input  evt_vec_t clr_bits,
    output evt_vec_t flags
);
    flag_state_t st_d, st_q;
    evt_vec_t    clr_eff;
    evt_vec_t    set_vec;

    // per-bit clear mapping; the valid flag also follows a measure clear
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_clr
        if (i == EV_VALID) begin : g_linked
            assign clr_eff[i] = clr_stb & (clr_bits[i] | clr_bits[EV_MEAS]);
        end else begin : g_plain
            assign clr_eff[i] = clr_stb & clr_bits[i];
        end
    end

    assign set_vec = evt & sig_en;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_eff) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;
endmodule

// File: rtl/evt_irq_readmux.sv
module evt_irq_readmux
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  evt_vec_t          flags,
    input  evt_vec_t          sig_en,
    input  evt_vec_t          irq_en,
    output evt_vec_t          rdata
);
    always_comb begin
        if (addr == ADDR_W'(ADDR_STAT)) begin
            rdata = flags;
        end else if (addr == ADDR_W'(ADDR_SIGEN)) begin
            rdata = sig_en;
        end else if (addr == ADDR_W'(ADDR_IRQEN)) begin
            rdata = irq_en;
        end else begin
            rdata = '0;
        end
    end
endmodule

// File: rtl/evt_irq_gate.sv
module evt_irq_gate
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [NUM_EVT-1:0]   reg_wdata,
    output logic [NUM_EVT-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0]   evt_pulse,
    output logic                 irq
);
    evt_vec_t status_q;
    evt_vec_t sig_en_q;
    evt_vec_t irq_en_q;
    logic     wr_stat, wr_sig, wr_irq;

    assign wr_stat = reg_wr && (reg_addr == ADDR_W'(ADDR_STAT));
    assign wr_sig  = reg_wr && (reg_addr == ADDR_W'(ADDR_SIGEN));
    assign wr_irq  = reg_wr && (reg_addr == ADDR_W'(ADDR_IRQEN));

    evt_irq_enables u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sig (wr_sig),
        .wr_irq (wr_irq),
        .wdata  (reg_wdata),
        .sig_en (sig_en_q),
        .irq_en (irq_en_q)
    );

    evt_irq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_pulse),
        .sig_en   (sig_en_q),
        .clr_stb  (wr_stat),
        .clr_bits (reg_wdata),
        .flags    (status_q)
    );

    evt_irq_readmux #(.ADDR_W(ADDR_W)) u_rd (
        .addr   (reg_addr),
        .flags  (status_q),
        .sig_en (sig_en_q),
        .irq_en (irq_en_q),
        .rdata  (reg_rdata)
    );

    // both gates must be open for a pending flag to reach the line
    assign irq = |(status_q & sig_en_q & irq_en_q);
endmodule

// File: rtl/evt_irq_gate_chk.sv
module evt_irq_gate_chk
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [NUM_EVT-1:0]  reg_wdata,
    input logic [NUM_EVT-1:0]  evt_pulse,
    input logic [NUM_EVT-1:0]  status_q,
    input logic [NUM_EVT-1:0]  sig_en_q,
    input logic [NUM_EVT-1:0]  irq_en_q,
    input logic                irq
);
    logic               stat_wr;
    logic [NUM_EVT-1:0] clr_hit;

    assign stat_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_STAT));

    always_comb begin
        for (int i = 0; i < NUM_EVT; i++) begin
            clr_hit[i] = stat_wr && (reg_wdata[i] || (i == EV_VALID && reg_wdata[EV_MEAS]));
        end
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        // R2
        a_r2_set_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(status_q[i]) && status_q[i]) |-> $past(evt_pulse[i] && sig_en_q[i]));
        // R6
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_pulse[i] && sig_en_q[i]) |=> status_q[i]);
        // R4
        a_r4_hold_unless_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[i] && !clr_hit[i]) |=> status_q[i]);
    end

    // R5
    a_r5_meas_clear_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata[EV_MEAS] && !(evt_pulse[EV_VALID] && sig_en_q[EV_VALID]))
        |=> !status_q[EV_VALID]);
    // R3
    a_r3_valid_ien_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_q[EV_VALID]);
    // R7
    a_r7_valid_alone_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == NUM_EVT'(1 << EV_VALID)) |-> !irq);
    // R8
    a_r8_no_capture_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_en_q == '0) |-> !irq);
    // R7
    a_r7_no_ien_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_q == '0) |-> !irq);
endmodule

bind evt_irq_gate evt_irq_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .evt_pulse (evt_pulse),
    .status_q  (status_q),
    .sig_en_q  (sig_en_q),
    .irq_en_q  (irq_en_q),
    .irq       (irq)
);

// File: tb/evt_irq_gate_tb.sv
`timescale 1ns/1ps
module evt_irq_gate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [3:0] reg_wdata = 4'd0;
    logic [3:0] reg_rdata;
    logic [3:0] evt_pulse = 4'd0;
    logic       irq;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    evt_irq_gate #(.ADDR_W(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 4'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [3:0] v);
        @(negedge clk);
        evt_pulse = v;
        @(negedge clk);
        evt_pulse = 4'd0;
    endtask

    function automatic logic exp_irq(input logic [3:0] st, input logic [3:0] s, input logic [3:0] e);
        return |(st & s & e & 4'b1011);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [3:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, d); chk("R1 status", d, 4'h0);
        rd(2'd1, d); chk("R1 capture enable", d, 4'h0);
        rd(2'd2, d); chk("R1 irq enable", d, 4'h0);
        chk("R1 irq", {3'b0, irq}, 4'h0);

        // R2 R7 exhaustive sweep
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 16; e++) begin
                for (int v = 0; v < 16; v++) begin
                    wr(2'd1, 4'(s));
                    wr(2'd2, 4'(e));
                    wr(2'd0, 4'hF);
                    pulse(4'(v));
                    rd(2'd0, d);
                    chk("R2 flags after pulse", d, 4'(v & s));
                    chk("R7 irq level", {3'b0, irq}, {3'b0, exp_irq(4'(v & s), 4'(s), 4'(e))});
                end
                rd(2'd2, d);
                chk("R3 irq enable readback", d, 4'(e & 4'b1011));
            end
        end

        // R3 valid-only with all enables requested
        wr(2'd1, 4'hF); wr(2'd2, 4'hF); wr(2'd0, 4'hF);
        pulse(4'b0100);
        chk("R3 valid flag no irq", {3'b0, irq}, 4'h0);

        // R4 partial clear and zero write
        pulse(4'b1011);
        wr(2'd0, 4'h0);
        rd(2'd0, d); chk("R4 zero write keeps", d, 4'hF);
        wr(2'd0, 4'b1000);
        rd(2'd0, d); chk("R4 partial clear", d, 4'b0111);

        // R5 measure clear takes valid along
        wr(2'd0, 4'b0001);
        rd(2'd0, d); chk("R5 measure clear drops valid", d, 4'b0010);
        pulse(4'b0101);
        wr(2'd0, 4'b0100);
        rd(2'd0, d); chk("R5 valid clear keeps measure", d, 4'b0011);

        // R6 set and clear on the same edge
        wr(2'd0, 4'hF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 4'b0010; evt_pulse = 4'b0010;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 4'd0; evt_pulse = 4'd0;
        rd(2'd0, d); chk("R6 set wins", d, 4'b0010);

        // R8 flag sticky when capture enable removed
        wr(2'd1, 4'b0000);
        rd(2'd0, d); chk("R8 flag kept", d, 4'b0010);
        chk("R8 irq gated off", {3'b0, irq}, 4'h0);
        wr(2'd1, 4'b0010);
        chk("R8 irq returns", {3'b0, irq}, 4'h1);

        // R9 unmapped address
        wr(2'd3, 4'hF);
        rd(2'd3, d); chk("R9 unmapped reads zero", d, 4'h0);
        rd(2'd0, d); chk("R9 status untouched", d, 4'b0010);
        rd(2'd1, d); chk("R9 capture untouched", d, 4'b0010);
        rd(2'd2, d); chk("R9 irq enable untouched", d, 4'b1011);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule